// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

The block keeps a sixteen-byte character store and refreshes a multiplexed display from it without help from the processor. A scan counter steps through the digit positions at a programmable rate. For each position it drives the scan lines and presents that position's stored byte on two 4-bit output nibbles. A blanking output is held high at the start of every digit period, so the display is dark while the digit drivers change over.

The processor reaches the block through a single write port. A select input marks each write as a command or as display data. Commands set the operating mode, the write position, the prescaler and a fill of the whole store with a blank character. Data writes land either at an auto-advancing address (left entry) or at the rightmost digit after the existing characters shift one place left (right entry). The store can be used as one array of bytes or as two independent arrays of nibbles, one for each output nibble.

Top module: `disp_refresh_ctrl`

## Requirements
- R1: While `rst` is high and on release, every position holds `BLANK_CODE`, the digit is 0, the mode is 16 digits of 8 bits with encoded scan and left entry, the write address is 0 and the prescaler value is 31.
- R2: In encoded scan, `scan` carries the binary number of the current digit; the digit counts up from 0 to the last digit (15 in 16-digit mode, 7 in 8-digit mode) and then returns to 0.
- R3: In decoded scan (mode bit 0 set), exactly one `scan` bit is high, bit `digit mod 4`, and only digits 0 to 3 are visited, whatever the digit-count bit says.
- R4: Each digit is shown for exactly (P+1)*`DWELL` clocks, where P is the prescaler value.
- R5: `blank` is high during the first P+1 clocks of each digit period and low for the rest of it, so it is high in every cycle in which the digit changes.
- R6: In left entry, a data write (`cmd_sel`=0) stores at the write address, and the address then advances by one, going from the last digit back to 0.
- R7: In right entry (mode bit 1 set), a data write moves every position from 1 to the last digit down by one place and stores the new value in the last digit.
- R8: In byte mode, `outa` shows bits 7:4 and `outb` shows bits 3:0 of the current digit's byte.
- R9: In nibble mode (mode bit 3 set), a data write stores `wr_data[3:0]` into the selected half only: half A (bits 7:4, shown on `outa`) or half B (bits 3:0, shown on `outb`). The other half of each position is unchanged. This applies to entry shifts as well.
- R10: The fill command (`wr_data[7:5]`=3'b110) loads `BLANK_CODE` into all 16 positions in one cycle.
- R11: The mode command (`wr_data[7:5]`=3'b000; bit 0 decoded, bit 1 right entry, bit 2 eight digits, bit 3 nibble mode) takes effect at once and restarts the scan at digit 0, at the start of its blanked interval.
- R12: The address command (`wr_data[7:5]`=3'b001) sets the write address to `wr_data[3:0]` and selects half B when `wr_data[4]` is 1. The prescaler command (`wr_data[7:5]`=3'b100) sets P to `wr_data[4:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write strobe |
| cmd_sel | input | 1 | 1: command write, 0: display data write |
| wr_data | input | 8 | Command word or display data |
| scan | output | 4 | Scan lines, binary or 1-of-4 |
| outa | output | 4 | Upper nibble or half A of the current digit |
| outb | output | 4 | Lower nibble or half B of the current digit |
| blank | output | 1 | Display blanking |

## Verification
The assertions assume that `rst` is high from time zero and that `DWELL` is at least 2. They also assume that each write is a single-cycle strobe. The bench drives every write as a one-cycle pulse between idle cycles, so the processor port never holds a write across two edges. After each group of writes, the bench issues a mode command so the scan restarts at a known cycle. It then walks every visible digit, sampling one cycle into the blanked interval and one cycle after it, and compares the outputs with a bench-side model of the store.

// File: rtl/disp_refresh_ctrl.sv
module disp_refresh_ctrl #(
  parameter int DWELL = 4,
  parameter logic [7:0] BLANK_CODE = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       cmd_sel,
  input  logic [7:0] wr_data,
  output logic [3:0] scan,
  output logic [3:0] outa,
  output logic [3:0] outb,
  output logic       blank
);

  localparam int NPOS = 16;
  localparam int DW = (DWELL > 1) ? $clog2(DWELL) : 1;

  logic [7:0]    ram [NPOS];
  logic [7:0]    nxt [NPOS];
  logic [3:0]    digit, addr, last;
  logic [4:0]    presc, pre_cnt;
  logic [DW-1:0] dwell_cnt;
  logic          decoded, right_ent, eight, split, half_b;

  wire data_wr  = wr_en & ~cmd_sel;
  wire cmd_wr   = wr_en & cmd_sel;
  wire mode_wr  = cmd_wr && wr_data[7:5] == 3'b000;
  wire addr_wr  = cmd_wr && wr_data[7:5] == 3'b001;
  wire presc_wr = cmd_wr && wr_data[7:5] == 3'b100;
  wire fill_wr  = cmd_wr && wr_data[7:5] == 3'b110;
  wire pre_wrap = pre_cnt == presc;
  wire dig_end  = pre_wrap && dwell_cnt == DW'(DWELL - 1);

  assign last  = decoded ? 4'd3 : (eight ? 4'd7 : 4'd15);
  assign scan  = decoded ? (4'b0001 << digit[1:0]) : digit;
  assign outa  = ram[digit][7:4];
  assign outb  = ram[digit][3:0];
  assign blank = dwell_cnt == '0;

  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      pre_cnt   <= '0;
      dwell_cnt <= '0;
      digit     <= '0;
    end else begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 5'd1;
      if (pre_wrap) dwell_cnt <= dig_end ? '0 : dwell_cnt + DW'(1);
      if (dig_end)  digit <= (digit >= last) ? 4'd0 : digit + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {split, eight, right_ent, decoded} <= 4'b0000;
      presc  <= 5'd31;
      addr   <= '0;
      half_b <= 1'b0;
    end else begin
      if (mode_wr)  {split, eight, right_ent, decoded} <= wr_data[3:0];
      if (presc_wr) presc <= wr_data[4:0];
      if (addr_wr) begin
        addr   <= wr_data[3:0];
        half_b <= wr_data[4];
      end
      if (data_wr) addr <= (addr >= last) ? 4'd0 : addr + 4'd1;
    end
  end

  always_comb begin
    for (int i = 0; i < NPOS; i++) begin
      logic       take;
      logic [7:0] src;
      logic [3:0] nib;
      take = 1'b0;
      src  = wr_data;
      if (right_ent) begin
        if (4'(i) < last) begin
          take = 1'b1;
          src  = ram[4'(i + 1)];
        end else if (4'(i) == last) begin
          take = 1'b1;
        end
      end else if (4'(i) == addr) begin
        take = 1'b1;
      end
      if (right_ent && 4'(i) < last) nib = half_b ? src[3:0] : src[7:4];
      else                           nib = src[3:0];
      nxt[i] = ram[i];
      if (take) begin
        if (!split)      nxt[i] = src;
        else if (half_b) nxt[i] = {ram[i][7:4], nib};
        else             nxt[i] = {nib, ram[i][3:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPOS; i++) begin
      if (rst || fill_wr) ram[i] <= BLANK_CODE;
      else if (data_wr)   ram[i] <= nxt[i];
    end
  end

  AST_SCAN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    decoded |-> $countones(scan) == 1); // R3

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    digit <= last); // R2

  AST_BLANK_ON_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (digit != $past(digit)) |-> blank); // R5

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (data_wr && addr == last) |=> addr == 4'd0); // R6

  AST_FILL_DONE: assert property (@(posedge clk) disable iff (rst)
    fill_wr |=> (ram[0] == BLANK_CODE && ram[NPOS-1] == BLANK_CODE)); // R10

endmodule

// File: tb/disp_refresh_ctrl_tb.sv
module disp_refresh_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL = 2;
  localparam logic [7:0] BL = 8'hE5;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, cmd_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] scan, outa, outb;
  logic blank;

  int checks = 0, errors = 0;
  logic [7:0] m [16];
  logic [7:0] bmode = 8'h00;
  logic [3:0] baddr = 4'd0;
  logic bhalf = 1'b0;

  disp_refresh_ctrl #(.DWELL(DWELL), .BLANK_CODE(BL)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_sel(cmd_sel), .wr_data(wr_data),
    .scan(scan), .outa(outa), .outb(outb), .blank(blank));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int blast();
    return bmode[0] ? 3 : (bmode[2] ? 7 : 15);
  endfunction

  function automatic logic [3:0] exps(input int k);
    return bmode[0] ? 4'(1 << (k % 4)) : 4'(k);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int i, input logic [3:0] v, input logic [7:0] full);
    if (!bmode[3])  m[i] = full;
    else if (bhalf) m[i][3:0] = v;
    else            m[i][7:4] = v;
  endtask

  task automatic cwr(input logic [7:0] c);
    @(negedge clk);
    wr_en = 1'b1; cmd_sel = 1'b1; wr_data = c;
    @(negedge clk);
    wr_en = 1'b0;
    case (c[7:5])
      3'b000: bmode = c;
      3'b001: begin baddr = c[3:0]; bhalf = c[4]; end
      3'b110: for (int i = 0; i < 16; i++) m[i] = BL;
      default: ;
    endcase
  endtask

  task automatic dwr(input logic [7:0] b);
    int lst;
    @(negedge clk);
    wr_en = 1'b1; cmd_sel = 1'b0; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    lst = blast();
    if (bmode[1]) begin
      for (int i = 0; i < lst; i++)
        put(i, bhalf ? m[i+1][3:0] : m[i+1][7:4], m[i+1]);
      put(lst, b[3:0], b);
    end else begin
      put(int'(baddr), b[3:0], b);
    end
    baddr = (int'(baddr) >= lst) ? 4'd0 : baddr + 4'd1;
  endtask

  task automatic readall(input string tag);
    cwr(bmode);
    for (int k = 0; k <= blast(); k++) begin
      chk(scan == exps(k), {tag, " R2 R3 scan"}, scan, exps(k));
      chk(blank == 1'b1, {tag, " R5 blank at switch"}, blank, 1);
      step();
      chk({outa, outb} == m[k], {tag, " R8 digit data"}, {outa, outb}, m[k]);
      chk(blank == 1'b0, {tag, " R5 blank after"}, blank, 0);
      step();
    end
    chk(scan == exps(0), {tag, " R2 R11 wrap"}, scan, exps(0));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m[i] = BL;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(scan == 4'd0, "R1 reset scan", scan, 0);
    chk({outa, outb} == BL, "R1 reset data", {outa, outb}, BL);
    chk(blank == 1'b1, "R1 reset blank", blank, 1);
    repeat (31) step();
    chk(blank == 1'b1, "R5 blank P+1=32 window end", blank, 1);
    step();
    chk(blank == 1'b0, "R5 blank off at 32", blank, 0);
    repeat (31) step();
    chk(scan == 4'd0, "R4 R1 dwell 64 hold", scan, 0);
    step();
    chk(scan == 4'd1, "R4 R1 dwell 64 advance", scan, 1);

    cwr(8'h80);
    readall("R1 all blank");

    cwr(8'h20);
    for (int i = 0; i < 18; i++) dwr(8'(i * 17 + 3));
    readall("R6 left wrap");

    cwr(8'h25);
    dwr(8'hA7);
    readall("R12 addr set");

    cwr(8'h02);
    dwr(8'h11); dwr(8'h22); dwr(8'h33);
    readall("R7 right entry");

    cwr(8'h06);
    dwr(8'h44); dwr(8'h55);
    readall("R7 R11 right 8-digit");
    cwr(8'h00);
    readall("R7 upper positions untouched");

    cwr(8'h08);
    cwr(8'h20);
    for (int i = 0; i < 4; i++) dwr(8'hF0 | 8'(i + 6));
    cwr(8'h30);
    for (int i = 0; i < 4; i++) dwr(8'hC0 | 8'(i + 10));
    readall("R9 nibble halves");
    cwr(8'h0A);
    cwr(8'h30);
    dwr(8'h0D);
    readall("R9 R7 nibble right");

    cwr(8'h01);
    cwr(8'h22);
    dwr(8'h91); dwr(8'h92); dwr(8'h93);
    readall("R3 R6 decoded wrap");

    cwr(8'hC0);
    cwr(8'h00);
    readall("R10 fill");

    cwr(8'h82);
    cwr(8'h00);
    repeat (2) step();
    chk(blank == 1'b1, "R5 R12 blank P=2", blank, 1);
    step();
    chk(blank == 1'b0, "R5 R12 blank off P=2", blank, 0);
    repeat (2) step();
    chk(scan == 4'd0, "R4 R12 hold P=2", scan, 0);
    step();
    chk(scan == 4'd1, "R4 R12 advance P=2", scan, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule